// File: doc/BRIEF.md
# Monochrome glyph bitmap expander

This block draws one text glyph into a framebuffer. A controller puts a command packet into a small word-addressed command memory and pulses `start`. The block reads the opcode word, two corner vertices and two color words. It then walks a 1-bit-per-pixel bitmap stored in the packet and emits one framebuffer pixel write per cycle, using the foreground color for set bits and the background color for clear bits.

The bitmap holds 22 rows of 16 pixels, packed two rows to a 32-bit word. These words do not sit in one contiguous range: eight come before the color words and three come after, with a gap of skipped words between them. The vertical coordinate in each vertex carries a bias of 63, which is removed before decoding. When the packet is finished, the block reports the rectangle it touched so that a display path can refresh only that area. The pixel format is either 24-bit gray or 8-bit indexed, chosen per packet.

Top module: `glyph_expander`

## Requirements
- R1: `start` is sampled only while idle. `busy` is high from the cycle after `start` until the last packet cycle. `done` is a single-cycle pulse with `busy` low, and the block then returns to idle. `start` held high during a run has no effect.
- R2: Expansion happens only when word 0 of the packet equals 32'h00000A21. Any other value ends the run with `done`, no framebuffer write, and `dirty_valid` low.
- R3: The start vertex is word 13, the end vertex is word 14, the foreground color is word 16 and the background color is word 29. Bitmap words 0..7 are read from words 4..11 and bitmap words 8..10 from words 30..32. No other word affects the result.
- R4: For a vertex v, x = v[29:19] reduced modulo 1280 and y = (((v - 63) >> 3) & 1023) reduced modulo 1024. The subtraction is a full 32-bit subtraction.
- R5: Bitmap word k holds row 2k in bits 15:0 and row 2k+1 in bits 31:16. Bit n of a row selects pixel n (1 = foreground, 0 = background). Row r is written at y = y1 + r, rows in order 0..21, with no wrap.
- R6: Each row writes w = x2 - x1 pixels when x2 > x1, otherwise none. Within a row, x rises by one per write from x1. Pixel columns 16 and above always take the background color.
- R7: With `depth24` high at `start`, a color word c maps to gray g on all three bytes: g = 0 when c[23:16] = 0, g = 192 when c[23:16] = 7, otherwise g = 255. With `depth24` low, the pixel is {16'h0, c[7:0]}.
- R8: With `done` on an expanding run, `dirty_valid` is high and the dirty rectangle is x from x1 to x2 and y from y1 to y1 + 21.
- R9: A framebuffer write happens only while `busy` and always has fb_x below 1280.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one packet |
| depth24 | input | 1 | 1 = 24-bit gray pixels, 0 = 8-bit pixels; sampled at start |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| cmd_addr | output | CMD_AW | Command memory word address |
| cmd_rdata | input | 32 | Command memory data, one cycle after address |
| fb_we | output | 1 | Framebuffer pixel write strobe |
| fb_x | output | 11 | Pixel column |
| fb_y | output | 11 | Pixel row |
| fb_data | output | 24 | Pixel value |
| dirty_valid | output | 1 | Dirty rectangle valid (with done) |
| dirty_x0 | output | 11 | Left edge of touched area |
| dirty_x1 | output | 11 | Right edge of touched area |
| dirty_y0 | output | 11 | Top row of touched area |
| dirty_y1 | output | 11 | Bottom row of touched area |

## Verification
The checker watches the handshake on every cycle. It checks that writes occur only during a run and stay inside the 1280-pixel width, that consecutive writes in a row step by one column, that `done` is a lone pulse that closes `busy`, and that the dirty strobe only appears with `done`. The pixel values are checked only by the bench scenarios: foreground and background selection per bit, the split bitmap word ranges, the vertex decode with its bias and modulo reduction, background fill beyond column 15, both color depths and the rejection of foreign opcodes. The bench compares every write against a model built from the requirements.

// File: rtl/glyph_expander.sv
module glyph_expander #(
  parameter int          FB_W   = 1280,
  parameter int          FB_H   = 1024,
  parameter int          CMD_AW = 6,
  parameter logic [31:0] OPCODE = 32'h0000_0A21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              depth24,
  output logic              busy,
  output logic              done,
  output logic [CMD_AW-1:0] cmd_addr,
  input  logic [31:0]       cmd_rdata,
  output logic              fb_we,
  output logic [10:0]       fb_x,
  output logic [10:0]       fb_y,
  output logic [23:0]       fb_data,
  output logic              dirty_valid,
  output logic [10:0]       dirty_x0,
  output logic [10:0]       dirty_x1,
  output logic [10:0]       dirty_y0,
  output logic [10:0]       dirty_y1
);
  localparam int XW = 11;
  localparam int YW = 11;
  localparam int LAST_WORD = 10;
  localparam int LAST_ROW  = 21;

  typedef enum logic [2:0] {S_IDLE, S_HRD, S_HCAP, S_BRD, S_BCAP, S_PIX, S_DONE} st_t;

  st_t         st;
  logic [2:0]  hidx;
  logic [31:0] cmd_w;
  logic [XW-1:0] v1x, v2x;
  logic [12:0] v1y;
  logic [15:0] fg, bg;
  logic [31:0] bm;
  logic [3:0]  widx;
  logic        half;
  logic [XW-1:0] pcnt;
  logic        mode24;

  logic [XW-1:0] x1, x2, width;
  logic [12:0]   ydiff;
  logic [YW-1:0] yraw, y1;
  logic          pix_on;

  function automatic logic [23:0] shade(input logic [15:0] c, input logic m24);
    logic [7:0] g;
    g = (c[15:8] == 8'd0) ? 8'd0 : (c[15:8] == 8'd7) ? 8'd192 : 8'd255;
    return m24 ? {g, g, g} : {16'h0, c[7:0]};
  endfunction

  assign x1     = (v1x >= XW'(FB_W)) ? v1x - XW'(FB_W) : v1x;
  assign x2     = (v2x >= XW'(FB_W)) ? v2x - XW'(FB_W) : v2x;
  assign width  = (x2 > x1) ? x2 - x1 : '0;
  assign ydiff  = v1y - 13'd63;
  assign yraw   = {1'b0, ydiff[12:3]};
  assign y1     = (yraw >= YW'(FB_H)) ? yraw - YW'(FB_H) : yraw;

  assign busy    = (st != S_IDLE) && (st != S_DONE);
  assign done    = (st == S_DONE);
  assign fb_we   = (st == S_PIX) && (width != '0);
  assign fb_x    = x1 + pcnt;
  assign fb_y    = y1 + YW'({widx, half});
  assign pix_on  = (pcnt < XW'(16)) && bm[{half, pcnt[3:0]}];
  assign fb_data = shade(pix_on ? fg : bg, mode24);

  assign dirty_valid = done && (cmd_w == OPCODE);
  assign dirty_x0    = x1;
  assign dirty_x1    = x2;
  assign dirty_y0    = y1;
  assign dirty_y1    = y1 + YW'(LAST_ROW);

  always_comb begin
    cmd_addr = '0;
    if (st == S_HRD) begin
      case (hidx)
        3'd0:    cmd_addr = CMD_AW'(0);
        3'd1:    cmd_addr = CMD_AW'(13);
        3'd2:    cmd_addr = CMD_AW'(14);
        3'd3:    cmd_addr = CMD_AW'(16);
        default: cmd_addr = CMD_AW'(29);
      endcase
    end else if (st == S_BRD) begin
      cmd_addr = (widx < 4'd8) ? CMD_AW'(widx) + CMD_AW'(4) : CMD_AW'(widx) + CMD_AW'(22);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; hidx <= '0; cmd_w <= '0; v1x <= '0; v2x <= '0; v1y <= '0;
      fg <= '0; bg <= '0; bm <= '0; widx <= '0; half <= 1'b0; pcnt <= '0; mode24 <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_HRD; hidx <= '0; mode24 <= depth24;
        end
        S_HRD: st <= S_HCAP;
        S_HCAP: begin
          case (hidx)
            3'd0:    cmd_w <= cmd_rdata;
            3'd1:    begin v1x <= cmd_rdata[29:19]; v1y <= cmd_rdata[12:0]; end
            3'd2:    v2x <= cmd_rdata[29:19];
            3'd3:    fg <= {cmd_rdata[23:16], cmd_rdata[7:0]};
            default: bg <= {cmd_rdata[23:16], cmd_rdata[7:0]};
          endcase
          if (hidx == 3'd4) begin
            widx <= '0; half <= 1'b0; pcnt <= '0;
            st <= (cmd_w == OPCODE) ? S_BRD : S_DONE;
          end else begin
            hidx <= hidx + 3'd1;
            st <= S_HRD;
          end
        end
        S_BRD:  st <= S_BCAP;
        S_BCAP: begin bm <= cmd_rdata; st <= S_PIX; end
        S_PIX: begin
          if (width == '0 || pcnt == width - XW'(1)) begin
            pcnt <= '0;
            half <= ~half;
            if (half) begin
              if (widx == 4'(LAST_WORD)) st <= S_DONE;
              else begin widx <= widx + 4'd1; st <= S_BRD; end
            end
          end else begin
            pcnt <= pcnt + XW'(1);
          end
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module glyph_expander_chk #(parameter int FB_W = 1280) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        fb_we,
  input logic [10:0] fb_x,
  input logic [10:0] fb_y,
  input logic        dirty_valid
);
  a_r9_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n) fb_we |-> busy);
  a_r9_x_in_frame: assert property (@(posedge clk) disable iff (!rst_n) fb_we |-> (int'(fb_x) < FB_W));
  a_r6_x_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_we && $past(fb_we) && fb_y == $past(fb_y)) |-> (fb_x == $past(fb_x) + 11'd1));
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r1_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r1_run_continues: assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done));
  a_r8_dirty_with_done: assert property (@(posedge clk) disable iff (!rst_n) dirty_valid |-> done);
endmodule

bind glyph_expander glyph_expander_chk #(.FB_W(FB_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fb_we(fb_we),
  .fb_x(fb_x), .fb_y(fb_y), .dirty_valid(dirty_valid)
);

// File: tb/glyph_expander_tb_top.sv
module glyph_expander_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OPC = 32'h0000_0A21;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, depth24 = 1'b1;
  logic busy, done, fb_we, dirty_valid;
  logic [5:0] cmd_addr;
  logic [31:0] cmd_rdata;
  logic [10:0] fb_x, fb_y, dirty_x0, dirty_x1, dirty_y0, dirty_y1;
  logic [23:0] fb_data;

  logic [31:0] mem [64];
  logic [31:0] bmw [11];
  int checks = 0, fails = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cmd_rdata <= mem[cmd_addr];

  glyph_expander dut_i (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      fails = fails + 1; checks = checks + 1;
      $display("FAIL watchdog: act=%0d exp<190000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int dec_x(input logic [31:0] v);
    return ((v >> 19) & 2047) % 1280;
  endfunction
  function automatic int dec_y(input logic [31:0] v);
    logic [31:0] d;
    d = v - 32'd63;
    return ((d >> 3) & 1023) % 1024;
  endfunction
  function automatic logic [23:0] color(input logic [31:0] c, input bit m24);
    logic [7:0] g;
    g = (c[23:16] == 0) ? 8'd0 : (c[23:16] == 7) ? 8'd192 : 8'd255;
    return m24 ? {g, g, g} : {16'h0, c[7:0]};
  endfunction
  function automatic int waddr(input int k);
    return (k < 8) ? 4 + k : 22 + k;
  endfunction
  function automatic logic [31:0] mkv(input int x, input int y);
    return ($urandom & 32'hC000_0000) | (32'(x) << 19) | 32'(y * 8 + 63 + ($urandom % 8));
  endfunction

  task automatic run(input logic [31:0] cmd, input logic [31:0] v1, input logic [31:0] v2,
                     input logic [31:0] fg, input logic [31:0] bg, input bit m24, input int hold);
    int ex1, ey1, ex2, ew, nwr, cyc, row, p, bad;
    bit go, bitv;
    logic [23:0] ed;
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    mem[0] = cmd; mem[13] = v1; mem[14] = v2; mem[16] = fg; mem[29] = bg;
    for (int k = 0; k < 11; k++) mem[waddr(k)] = bmw[k];
    ex1 = dec_x(v1); ey1 = dec_y(v1); ex2 = dec_x(v2);
    ew = (ex2 > ex1) ? ex2 - ex1 : 0;
    go = (cmd == OPC);
    depth24 = m24; start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 busy after start", int'(busy), 1);
    repeat (hold) @(negedge clk);
    start = 1'b0;
    nwr = 0; cyc = 0; bad = 0;
    forever begin
      if (fb_we) begin
        row = (ew > 0) ? nwr / ew : 99;
        p   = (ew > 0) ? nwr % ew : 0;
        bitv = (row < 22 && p < 16) ? bmw[row / 2][(row % 2) * 16 + p] : 1'b0;
        ed = color(bitv ? fg : bg, m24);
        if (bad == 0 && (!go || row >= 22 || fb_x != 11'(ex1 + p) || fb_y != 11'(ey1 + row) || fb_data != ed)) begin
          bad = 1;
          $display("FAIL R5/R6/R7 write %0d: act x=%0d y=%0d d=%0h exp x=%0d y=%0d d=%0h",
                   nwr, fb_x, fb_y, fb_data, ex1 + p, ey1 + row, ed);
        end
        nwr++;
      end
      if (done || cyc > 20000) break;
      @(negedge clk); cyc++;
    end
    checks++; if (bad != 0) fails++;
    chk(done == 1'b1, "R1 done reached", int'(done), 1);
    chk(busy == 1'b0, "R1 busy low with done", int'(busy), 0);
    chk(nwr == (go ? 22 * ew : 0), go ? "R6 write count" : "R2 no writes", nwr, go ? 22 * ew : 0);
    chk(dirty_valid == go, "R8/R2 dirty_valid", int'(dirty_valid), int'(go));
    if (go) begin
      chk(dirty_x0 == 11'(ex1) && dirty_x1 == 11'(ex2), "R8 dirty x", {dirty_x0, dirty_x1}, {11'(ex1), 11'(ex2)});
      chk(dirty_y0 == 11'(ey1) && dirty_y1 == 11'(ey1 + 21), "R8 dirty y", {dirty_y0, dirty_y1}, {11'(ey1), 11'(ey1 + 21)});
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R1 done single pulse", {done, busy}, 0);
  endtask

  function automatic logic [31:0] rcol();
    int s;
    s = $urandom % 3;
    return (s == 0) ? ($urandom & 32'hFF00_FFFF) : (s == 1) ? (($urandom & 32'hFF00_FFFF) | 32'h0007_0000)
                                                : ($urandom | 32'h0010_0000);
  endfunction

  initial begin
    void'($urandom(32'h5EED_0A21));
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && fb_we == 0 && dirty_valid == 0, "R1 reset state",
        {busy, done, fb_we, dirty_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 11; k++) bmw[k] = $urandom;
    // R5 R3: basic 16-wide glyph, 24-bit gray, both gray special codes
    run(OPC, mkv(100, 200), mkv(116, 0), 32'h0007_0000, 32'h0000_00FF, 1'b1, 0);
    // R6: width 20, columns 16..19 take background
    for (int k = 0; k < 11; k++) bmw[k] = 32'hFFFF_FFFF;
    run(OPC, mkv(40, 10), mkv(60, 5), 32'h00FF_0000, 32'h0000_0000, 1'b1, 0);
    // R6: end before start gives no writes
    run(OPC, mkv(500, 10), mkv(400, 5), 32'h00FF_0000, 32'h0, 1'b1, 0);
    // R4: raw x at or above 1280 wraps
    for (int k = 0; k < 11; k++) bmw[k] = $urandom;
    run(OPC, mkv(1300, 50), mkv(1310, 50), 32'h0001_0000, 32'h0007_0000, 1'b1, 0);
    // R4: low vertex field below the bias borrows
    run(OPC, 32'(300) << 19, 32'(308) << 19, 32'h00AA_0000, 32'h0, 1'b1, 0);
    // R7: 8-bit mode uses low byte
    run(OPC, mkv(0, 1000), mkv(12, 0), 32'h0000_005A, 32'h00FF_00C3, 1'b0, 0);
    // R2: foreign opcodes
    run(32'h0000_0A20, mkv(10, 10), mkv(20, 10), 32'h1, 32'h2, 1'b1, 0);
    run(32'h0000_0405, mkv(10, 10), mkv(20, 10), 32'h1, 32'h2, 1'b1, 0);
    // R1: start held through the run is ignored
    run(OPC, mkv(700, 300), mkv(705, 300), 32'h0007_0000, 32'h0, 1'b1, 3);
    // R3..R7 random mix
    for (int n = 0; n < 30; n++) begin
      int xa, w;
      for (int k = 0; k < 11; k++) bmw[k] = $urandom;
      xa = $urandom % 1280; w = $urandom % 25;
      run(OPC, mkv(xa, $urandom % 1024), mkv(($urandom % 4 == 0) ? $urandom % 2048 : xa + w, $urandom % 1024),
          rcol(), rcol(), 1'($urandom % 2), 0);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule